// File: doc/BRIEF.md
# Compare-Match Pulse Output Controller

This block turns two compare events from a 16-bit free-running timer into level changes on a group of pulse output pins. Two compare values, A and B, are held in registers. When the counter reaches compare value A, a set event fires. When it reaches compare value B, a reset event fires. A 16-bit control word decides which pins each event reaches. The low half holds a per-pin set mask and the high half holds a per-pin reset mask, so a single pair of events can produce different waveforms on different pins.

Each pin also has a function-select input. A pin takes part only when its select is high and at least one of its two mask bits is set. While a pin does not take part it drives 0 and its stored level stays at 0. As a result, a pin that has just been enabled drives 0 until the first event that reaches it. Software loads the control word and both compare values through a simple synchronous write port.

Top module: `pcc_pulse_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the control word, both compare values, the counter and every pin level, so `pulse_out` reads 0 after reset.
- R2: The counter increments by one on each clock while `cnt_en` is high, wraps modulo 2^16, and holds its value while `cnt_en` is low. A compare event fires only in a cycle where `cnt_en` is high and the counter equals the compare value.
- R3: When the counter equals compare A, every participating pin whose set-mask bit (control bit i, for pin i) is 1 drives 1 from the next clock edge onward.
- R4: When the counter equals compare B, every participating pin whose reset-mask bit (control bit 8+i, for pin i) is 1 drives 0 from the next clock edge onward.
- R5: A pin whose select input is 0, or whose two mask bits are both 0, drives 0 in the same cycle, and its stored level is forced to 0.
- R6: A pin that has just started to participate drives 0 until the first compare event that reaches it.
- R7: If both events reach a pin in the same cycle, the reset wins and the pin drives 0.
- R8: The masks act independently. A pin without a reset bit keeps its 1 through a B event, and a pin without a set bit is not raised by an A event.
- R9: A write with `wr_en` high stores `wr_data` at the next edge. Address 0 holds the control word, address 1 holds compare A and address 2 holds compare B.
- R10: A new control word or compare value applies to compare events from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 compare A, 2 compare B) |
| wr_data | input | 16 | Register write data |
| cnt_en | input | 1 | Counter run enable |
| pin_sel | input | 8 | Per-pin function select, 1 selects pulse mode |
| pulse_out | output | 8 | Pulse output levels |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any activity. They also assume that `pin_sel` and `cnt_en` change only between clock edges. They do not rely on any particular ordering of writes against compare events, so register writes may land while the counter runs. The stimulus drives every input at the falling edge, and every scenario starts from a fresh reset with the counter stopped. Compare values are kept small so that the matches fall within a few dozen cycles, and the bench counts edges from the moment the counter is enabled to predict when each match occurs.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int NPIN_DEF  = 8;
  localparam int CNT_W_DEF = 16;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CMP_A = 2'd1;
  localparam logic [1:0] ADDR_CMP_B = 2'd2;

  // next stored level of one pin: inactive clears, reset beats set, else hold
  function automatic logic pin_next(input logic cur, input logic active,
                                    input logic set_ev, input logic clr_ev);
    logic nxt;
    if (!active)      nxt = 1'b0;
    else if (clr_ev)  nxt = 1'b0;
    else if (set_ev)  nxt = 1'b1;
    else              nxt = cur;
    return nxt;
  endfunction

  function automatic logic pin_active(input logic sel, input logic set_bit,
                                      input logic clr_bit);
    return sel & (set_bit | clr_bit);
  endfunction
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs #(
  parameter int NPIN  = pcc_pkg::NPIN_DEF,
  parameter int CNT_W = pcc_pkg::CNT_W_DEF,
  localparam int CTRL_W = 2 * NPIN,
  localparam int DATA_W = (CTRL_W > CNT_W) ? CTRL_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  cmp_a_q,
  output logic [CNT_W-1:0]  cmp_b_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        pcc_pkg::ADDR_CTRL:  ctrl_q  <= wr_data[CTRL_W-1:0];
        pcc_pkg::ADDR_CMP_A: cmp_a_q <= wr_data[CNT_W-1:0];
        pcc_pkg::ADDR_CMP_B: cmp_b_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcc_timebase.sv
module pcc_timebase #(
  parameter int CNT_W = pcc_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_a,
  output logic             match_b
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign match_a = cnt_en & (cnt_q == cmp_a);
  assign match_b = cnt_en & (cnt_q == cmp_b);
endmodule

// File: rtl/pcc_pin_cell.sv
module pcc_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic set_bit,
  input  logic clr_bit,
  input  logic match_a,
  input  logic match_b,
  output logic state_q,
  output logic active,
  output logic pin_o
);
  logic set_ev;
  logic clr_ev;

  assign active = pcc_pkg::pin_active(sel, set_bit, clr_bit);
  assign set_ev = match_a & set_bit;
  assign clr_ev = match_b & clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= pcc_pkg::pin_next(state_q, active, set_ev, clr_ev);
  end

  assign pin_o = state_q & active;
endmodule

// File: rtl/pcc_pulse_ctrl.sv
module pcc_pulse_ctrl #(
  parameter int NPIN  = pcc_pkg::NPIN_DEF,
  parameter int CNT_W = pcc_pkg::CNT_W_DEF,
  localparam int CTRL_W = 2 * NPIN,
  localparam int DATA_W = (CTRL_W > CNT_W) ? CTRL_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_en,
  input  logic [NPIN-1:0]   pin_sel,
  output logic [NPIN-1:0]   pulse_out
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_a_q;
  logic [CNT_W-1:0]  cmp_b_q;
  logic [CNT_W-1:0]  cnt_val;
  logic              match_a;
  logic              match_b;
  logic [NPIN-1:0]   pin_state;
  logic [NPIN-1:0]   pin_act;

  pcc_regs #(.NPIN(NPIN), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q)
  );

  pcc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cmp_a(cmp_a_q),
    .cmp_b(cmp_b_q), .cnt_q(cnt_val), .match_a(match_a), .match_b(match_b)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pcc_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .sel(pin_sel[i]),
      .set_bit(ctrl_q[i]), .clr_bit(ctrl_q[NPIN+i]),
      .match_a(match_a), .match_b(match_b),
      .state_q(pin_state[i]), .active(pin_act[i]), .pin_o(pulse_out[i])
    );
  end
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int NPIN  = 8,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [NPIN-1:0]   pin_sel,
  input logic [NPIN-1:0]   pulse_out,
  input logic [2*NPIN-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              match_a,
  input logic              match_b,
  input logic [NPIN-1:0]   pin_state
);
  logic [NPIN-1:0] part_v, set_v, clr_v;
  assign part_v = pin_sel & (ctrl_q[NPIN-1:0] | ctrl_q[2*NPIN-1:NPIN]);
  assign set_v  = match_a ? (ctrl_q[NPIN-1:0] & part_v) : '0;
  assign clr_v  = match_b ? (ctrl_q[2*NPIN-1:NPIN] & part_v) : '0;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pulse_out == '0 && cnt_val == '0));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_val));

  p_match_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a | match_b) |-> cnt_en);

  p_set_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_v & ~clr_v) |=> (pin_state & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v));

  p_clear_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_v |=> (pin_state & $past(clr_v)) == '0);

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |(~part_v) |=> (pin_state & $past(~part_v)) == '0);

  p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out & ~pin_sel) == '0);

  p_hold_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_a && !match_b) |=> (pin_state & $past(part_v)) == ($past(pin_state) & $past(part_v)));
endmodule

bind pcc_pulse_ctrl pcc_checker #(.NPIN(NPIN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_sel(pin_sel),
  .pulse_out(pulse_out), .ctrl_q(ctrl_q), .cnt_val(cnt_val),
  .match_a(match_a), .match_b(match_b), .pin_state(pin_state)
);

// File: tb/sim_pcc_pulse_ctrl.sv
`timescale 1ns/1ps
module sim_pcc_pulse_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cnt_en = 1'b0;
  logic [7:0]  pin_sel = '0;
  logic [7:0]  pulse_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pcc_pulse_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .pin_sel(pin_sel), .pulse_out(pulse_out)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (pulse_out !== exp) begin
      n_err++;
      $display("FAIL %s: pulse_out=%h expected=%h", req, pulse_out, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; pin_sel = '0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [15:0] c, input logic [15:0] ca,
                       input logic [15:0] cb, input logic [7:0] s);
    do_reset();
    wr(2'd0, c); wr(2'd1, ca); wr(2'd2, cb);
    pin_sel = s;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", 8'h00);
  endtask

  task automatic t_basic();
    setup(16'hFFFF, 16'd4, 16'd9, 8'hFF);
    cnt_en = 1'b1;
    step(4);  chk("R6 low before A", 8'h00);
    step(1);  chk("R3 set on A", 8'hFF);
    step(4);  chk("R3 held until B", 8'hFF);
    step(1);  chk("R4 clear on B", 8'h00);
  endtask

  task automatic t_masks();
    // set pins 0-3, reset pins 0,1,4,5 (R8, R9 address map)
    setup(16'h330F, 16'd2, 16'd5, 8'hFF);
    cnt_en = 1'b1;
    step(3); chk("R8 set mask only", 8'h0F);
    step(3); chk("R8 reset mask only", 8'h0C);
  endtask

  task automatic t_select();
    setup(16'hFFFF, 16'd1, 16'd7, 8'h0F);
    cnt_en = 1'b1;
    step(2); chk("R5 unselected stay low", 8'h0F);
  endtask

  task automatic t_same_cycle();
    setup(16'h0FFF, 16'd3, 16'd3, 8'hFF);
    cnt_en = 1'b1;
    step(4); chk("R7 reset wins", 8'hF0);
  endtask

  task automatic t_disabled();
    setup(16'h00FF, 16'd0, 16'd9, 8'hFF);
    step(5); chk("R2 no event while stopped", 8'h00);
    cnt_en = 1'b1;
    step(1); chk("R2 counter held at zero", 8'hFF);
  endtask

  task automatic t_ctrl_update();
    setup(16'h00FF, 16'd2, 16'd6, 8'hFF);
    cnt_en = 1'b1;
    step(3); chk("R3 set before update", 8'hFF);
    wr(2'd0, 16'hFFFF);
    step(2); chk("R10 held before B", 8'hFF);
    step(1); chk("R10 new reset mask applied", 8'h00);
  endtask

  task automatic t_reselect();
    setup(16'h00FF, 16'd2, 16'd100, 8'hFF);
    cnt_en = 1'b1;
    step(3); chk("R3 set", 8'hFF);
    pin_sel = 8'h00;
    #1; chk("R5 deselect drives low", 8'h00);
    step(1);
    pin_sel = 8'hFF;
    #1; chk("R6 low after reselect", 8'h00);
    wr(2'd1, 16'd8);
    step(3); chk("R6 low until next A", 8'h00);
    step(1); chk("R10 new compare A used", 8'hFF);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_masks();
    t_select();
    t_same_cycle();
    t_disabled();
    t_ctrl_update();
    t_reselect();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule